// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter built from identical 4-bit slices. Each slice holds a binary count that can be cleared at once, loaded in parallel on a clock edge, counted up, or held. The slice has two count enables. Both must be high for the slice to count, and only one of them, the trickle enable, also gates the slice's terminal-count output. Because of this, slices can be joined without a ripple path through the count registers.

The top module joins a parameterised number of slices into one wide counter. A single load strobe, a single data word and a single count enable reach every slice. Each slice's trickle enable comes from the terminal count of the slice below it. The lowest slice's trickle enable is the common count enable. The result behaves as one binary counter of the full width. It also gives a final terminal-count flag that can enable a further stage.

Top module: `casc_counter`

## Requirements
- R1: All count bits change only on the rising clock edge, except when cleared. Loading and counting take effect at that edge, all slices together.
- R2: When `clr_n` goes low, `count` becomes zero at once without waiting for a clock edge, and stays zero while `clr_n` is low, whatever `load_n`, `cnt_en` and `load_data` do.
- R3: With `clr_n` high and `load_n` low at a rising edge, `count` takes the value of `load_data`, whether `cnt_en` is high or low.
- R4: Clear wins over load: a rising edge with both `clr_n` and `load_n` low leaves `count` at zero.
- R5: With `clr_n` and `load_n` high and `cnt_en` high at a rising edge, `count` goes up by one as a single full-width binary number. Carries pass between slices in the same edge, and all ones wraps to zero.
- R6: With `clr_n` and `load_n` high and `cnt_en` low at a rising edge, `count` holds its value.
- R7: `tc_out` is high exactly when `count` is all ones and `cnt_en` is high. It follows `cnt_en` combinationally.
- R8: Each slice is 4 bits wide. The counter width is 4 × `N_SLICES`. Slice k counts only when slice k-1's terminal count is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Common count enable |
| load_data | input | 4*N_SLICES | Value to load |
| count | output | 4*N_SLICES | Current count |
| tc_out | output | 1 | Final terminal count |

## Verification
The assertions check every cycle, slice by slice, that a load takes the data, that a disabled slice holds, and that an enabled slice increments. At the top they check full-width increments with carry, that a rising clear edge leaves zero, and that the terminal flag appears only at all ones. The bench scenarios are the only evidence of the immediate effect of a clear asserted mid-cycle and of clear winning over a load. They also cover wraparound across every slice boundary and a terminal flag that stays low at all ones while the enable is low.

// File: rtl/casc_counter_pkg.sv
package casc_counter_pkg;

    localparam int SLICE_W = 4;

    typedef logic [SLICE_W-1:0] nib_t;

    typedef struct packed {
        logic load_n;
        logic en_p;
        logic en_t;
    } slice_ctl_t;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2
    } slice_act_e;

    function automatic slice_act_e pick_act(input slice_ctl_t c);
        if (!c.load_n)
            return ACT_LOAD;
        else if (c.en_p && c.en_t)
            return ACT_COUNT;
        else
            return ACT_HOLD;
    endfunction

    function automatic nib_t next_nib(input slice_act_e a, input nib_t q, input nib_t d);
        case (a)
            ACT_LOAD:  return d;
            ACT_COUNT: return q + nib_t'(1);
            default:   return q;
        endcase
    endfunction

endpackage

// File: rtl/cnt_term.sv
module cnt_term
    import casc_counter_pkg::*;
(
    input  nib_t q,
    input  logic en_t,
    output logic tc
);
    always_comb tc = en_t & (&q);
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
    import casc_counter_pkg::*;
(
    input  logic       clk,
    input  logic       clr_n,
    input  slice_ctl_t ctl,
    input  nib_t       d,
    output nib_t       q,
    output logic       tc
);
    slice_act_e act;
    nib_t       q_r;

    always_comb act = pick_act(ctl);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            q_r <= '0;
        else
            q_r <= next_nib(act, q_r, d);
    end

    assign q = q_r;

    cnt_term term_i (
        .q    (q_r),
        .en_t (ctl.en_t),
        .tc   (tc)
    );

    // R3
    slice_load_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !ctl.load_n |=> q == $past(d));

    // R6
    slice_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        ctl.load_n && !(ctl.en_p && ctl.en_t) |=> $stable(q));

    // R5
    slice_incr_chk: assert property (@(posedge clk) disable iff (!clr_n)
        ctl.load_n && ctl.en_p && ctl.en_t |=> q == $past(q) + nib_t'(1));

endmodule

// File: rtl/casc_counter.sv
module casc_counter
    import casc_counter_pkg::*;
#(
    parameter int N_SLICES = 3,
    localparam int W = SLICE_W * N_SLICES
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic         cnt_en,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] count,
    output logic         tc_out
);
    logic [N_SLICES-1:0] tc_v;

    for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
        slice_ctl_t ctl;
        nib_t       q;
        logic       carry_in;

        if (k == 0) begin : g_first
            assign carry_in = cnt_en;
        end else begin : g_next
            assign carry_in = tc_v[k-1];
        end

        always_comb begin
            ctl.load_n = load_n;
            ctl.en_p   = cnt_en;
            ctl.en_t   = carry_in;
        end

        cnt_slice slice_i (
            .clk   (clk),
            .clr_n (clr_n),
            .ctl   (ctl),
            .d     (load_data[k*SLICE_W +: SLICE_W]),
            .q     (q),
            .tc    (tc_v[k])
        );

        assign count[k*SLICE_W +: SLICE_W] = q;
    end

    assign tc_out = tc_v[N_SLICES-1];

    // R5
    wide_incr_chk: assert property (@(posedge clk) disable iff (!clr_n)
        load_n && cnt_en |=> count == $past(count) + W'(1));

    // R2
    clr_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(clr_n) |-> count == '0);

    // R7
    term_flag_chk: assert property (@(posedge clk) disable iff (!clr_n)
        tc_out |-> (count == '1 && cnt_en));

endmodule

// File: tb/casc_counter_tb.sv
module casc_counter_tb_top;
    localparam int N_SLICES = 3;
    localparam int W = 4 * N_SLICES;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         clr_n;
    logic         load_n;
    logic         cnt_en;
    logic [W-1:0] load_data;
    logic [W-1:0] count;
    logic         tc_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] model = '0;

    typedef struct {
        logic [W-1:0] exp_cnt;
        logic         exp_tc;
        int           req;
    } item_t;

    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    casc_counter #(.N_SLICES(N_SLICES)) dut_i (
        .clk       (clk),
        .clr_n     (clr_n),
        .load_n    (load_n),
        .cnt_en    (cnt_en),
        .load_data (load_data),
        .count     (count),
        .tc_out    (tc_out)
    );

    task automatic check(input logic [W-1:0] c, input logic t, input int req);
        n_checks++;
        if (count !== c || tc_out !== t) begin
            n_fail++;
            $display("FAIL R%0d: count=%h tc=%b expected count=%h tc=%b",
                     req, count, tc_out, c, t);
        end
    endtask

    // driver: apply one cycle of inputs and queue the expected result
    task automatic step(input logic ld_n, input logic en,
                        input logic [W-1:0] data, input int req);
        item_t it;
        @(negedge clk);
        load_n    = ld_n;
        cnt_en    = en;
        load_data = data;
        if (!ld_n)     model = data;
        else if (en)   model = model + W'(1);
        it.exp_cnt = model;
        it.exp_tc  = en && (model == '1);
        it.req     = req;
        exp_q.push_back(it);
    endtask

    // monitor: compare just after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            check(it.exp_cnt, it.exp_tc, it.req);
        end
    end

    task automatic mid_cycle_clear(input logic [W-1:0] data);
        @(negedge clk);
        #2;
        load_n    = 1'b0;
        load_data = data;
        clr_n     = 1'b0;
        #1;
        check('0, 1'b0, 2); // R2: zero before any edge
        @(posedge clk);
        #1;
        check('0, 1'b0, 4); // R4: clear beats load
        model = '0;
        @(negedge clk);
        clr_n  = 1'b1;
        load_n = 1'b1;
        cnt_en = 1'b0;
    endtask

    initial begin
        clr_n = 1'b0; load_n = 1'b1; cnt_en = 1'b0; load_data = '0;
        #(CLK_PERIOD * 2 + 3);
        check('0, 1'b0, 2);           // R2: reset state
        @(negedge clk);
        clr_n = 1'b1;

        step(1'b1, 1'b1, '0, 5);      // R5 count 1
        step(1'b1, 1'b1, '0, 5);      // R5 count 2
        step(1'b1, 1'b0, '0, 6);      // R6 hold
        step(1'b1, 1'b0, 'h7A5, 6);   // R6 hold, data ignored
        step(1'b0, 1'b0, 'h00E, 3);   // R3 load with enable low
        step(1'b1, 1'b1, '0, 5);      // R5 -> 00F
        step(1'b1, 1'b1, '0, 8);      // R8 carry into slice 1 -> 010
        step(1'b0, 1'b1, 'h0FE, 3);   // R3 load with enable high
        step(1'b1, 1'b1, '0, 5);      // R5 -> 0FF
        step(1'b1, 1'b1, '0, 8);      // R8 carry through two slices -> 100
        step(1'b0, 1'b1, 'hFFD, 1);   // R1 synchronous load
        step(1'b1, 1'b1, '0, 5);      // R5 -> FFE
        step(1'b1, 1'b1, '0, 7);      // R7 -> FFF, tc high
        step(1'b1, 1'b1, '0, 5);      // R5 wrap -> 000
        step(1'b0, 1'b0, 'hFFF, 7);   // R7 all ones, enable low, tc low
        step(1'b1, 1'b0, '0, 7);      // R7 still low while held
        step(1'b1, 1'b1, '0, 5);      // R5 wrap again
        step(1'b0, 1'b1, 'h5C3, 3);   // R3
        step(1'b1, 1'b1, '0, 1);      // R1
        wait (exp_q.size() == 0);
        @(negedge clk);

        mid_cycle_clear('h9AB);       // R2 R4
        step(1'b1, 1'b1, '0, 5);      // R5 count from cleared
        step(1'b0, 1'b1, 'h3FF, 3);   // R3
        step(1'b1, 1'b1, '0, 8);      // R8 -> 400
        wait (exp_q.size() == 0);
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule